// File: doc/BRIEF.md
# Encoder-capable up/down timer counter

This block is a timer counter whose count clock and count direction are chosen by a 3-bit slave-mode select. It can count the internal clock or decode two external pins as a quadrature position encoder, with one pin as the count clock and the other as direction, or with x4 decoding of both pins. It can also let an external pin gate the count, start it, or reload it. The counter runs between zero and an active preset (auto-reload) value. It raises a one-cycle event pulse on every overflow or underflow. The preset can be written straight into the active copy or through a shadow copy that takes effect at the next event.

The block is driven by plain control strobes and has no streaming data path, so there is no valid/ready handshake. A write strobe acts in the cycle it is sampled. Both external pins cross into the clock domain through a two-flop synchroniser. A pin change therefore reaches the counter on the third rising clock edge after it is applied.

Top module: `enc_timer`

## Requirements
- R1: After reset the count is 0, the active preset reads all ones, the direction bit is 0 and the event output is low.
- R2: In mode 0 (internal clock) the count steps by one on every clock while `en_i` is 1: up when the direction bit is 0 and down when it is 1. While `en_i` is 0 the count holds and no event is raised in any mode.
- R3: Counting up from a count equal to the active preset gives 0. Counting down from 0 reloads the active preset. Either wrap drives `event_o` high for exactly the one cycle in which the wrapped value first appears on `cnt_o`.
- R4: In mode 1 the count steps once per rising edge of `pin_b_i`. It counts down when `pin_a_i` is 1 and up when it is 0, and `dir_o` shows the decoded direction.
- R5: In mode 2 the count steps once per rising edge of `pin_a_i`. The direction comes from the level of `pin_b_i`, with 1 meaning down.
- R6: In mode 3 every rising or falling edge of either pin steps the count (x4 decoding). The step is up when `pin_a_i` leads `pin_b_i`, where the new A level differs from the old B level, and down otherwise. A cycle in which both synchronised pins change is not counted.
- R7: In mode 4 a rising edge of `pin_a_i` reloads the count: to 0 when the direction is up, or to the active preset when it is down. The reload raises no event. In every other cycle the count steps on the internal clock.
- R8: In mode 5 the count steps on the internal clock only while the synchronised `pin_a_i` is 1. It holds its value, without clearing, while the pin is 0.
- R9: In mode 6 the count holds until a rising edge of `pin_a_i` is seen, without clearing the count. From the following cycle it steps on every clock until the mode changes away from 6.
- R10: When `preload_en_i` is 1, a preset write goes to a shadow copy and `preset_o` does not change until the next event, when the shadow value becomes active. A down-count reload at that event uses the new value. When `preload_en_i` is 0, a preset write becomes active on the next cycle.
- R11: A count write (`cnt_wr_i`) loads `cnt_wdata_i` on the next cycle. It takes priority over stepping, reloading and wrapping, and it works while `en_i` is 0.
- R12: In modes 1 to 3 the direction bit is driven only by the decoder and `dir_wr_i` is ignored. Mode 7 never steps or reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global count enable |
| mode_i | input | 3 | Slave mode select, 0 to 7 as listed in the requirements |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Count write value |
| preset_wr_i | input | 1 | Preset write strobe |
| preset_wdata_i | input | CNT_W | Preset write value |
| preload_en_i | input | 1 | 1: preset writes go through the shadow copy |
| dir_wr_i | input | 1 | Direction write strobe |
| dir_wdata_i | input | 1 | Direction write value, 0 up and 1 down |
| pin_a_i | input | 1 | External pin A, asynchronous |
| pin_b_i | input | 1 | External pin B, asynchronous |
| cnt_o | output | CNT_W | Current count |
| preset_o | output | CNT_W | Active preset |
| dir_o | output | 1 | Direction bit, 0 up and 1 down |
| event_o | output | 1 | One-cycle overflow or underflow pulse |

## Verification
The bench targets the wrap boundaries and the preset handling. A design that compared against the shadow preset instead of the active one, or that reloaded a down-count with the old preset, would wrap at the wrong value. A design that delayed the event pulse by a cycle would show a pulse that does not line up with the wrapped count. The bench also pushes x4 phase sequences in both rotation directions and occasional illegal double changes, which expose a swapped phase rule or a double step. Count writes that land in wrap cycles and direction writes made in encoder modes would expose a wrong priority between software and hardware. A cycle-level reference model follows every output, including the three-edge latency of the pin synchroniser, so an extra or missing flop stage shows up as a one-cycle skew.

// File: rtl/enc_timer_pkg.sv
package enc_timer_pkg;

  typedef enum logic [2:0] {
    MODE_INTCLK = 3'd0,
    MODE_ENC_B  = 3'd1,
    MODE_ENC_A  = 3'd2,
    MODE_ENC_X4 = 3'd3,
    MODE_REINIT = 3'd4,
    MODE_GATED  = 3'd5,
    MODE_TRIG   = 3'd6
  } tmr_mode_e;

  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PIN_A    = 0;
  localparam int unsigned PIN_B    = 1;

  typedef struct packed {
    logic step;    // advance the count this cycle
    logic down;    // step direction, 1 = down
    logic reinit;  // reload the count from the start value
    logic hw_dir;  // direction bit is owned by the decoder
  } step_req_t;

endpackage

// File: rtl/enc_pin_sync.sv
module enc_pin_sync #(
  parameter int unsigned NPINS  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] prev_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [DEPTH-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[DEPTH-2:0], pins_i[g]};
    end
    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign prev_o[g] = pipe_q[STAGES];
  end

endmodule

// File: rtl/enc_mode_decode.sv
module enc_mode_decode
  import enc_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic                dir_i,
  output step_req_t           req_o
);

  logic [NUM_PINS-1:0] rise, fall, chg;
  logic                trig_q;

  assign rise = lvl_i & ~prev_i;
  assign fall = ~lvl_i & prev_i;
  assign chg  = rise | fall;

  // trigger mode: latch the start edge, drop it when leaving the mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    trig_q <= 1'b0;
    else if (mode_i == MODE_TRIG)  trig_q <= trig_q | rise[PIN_A];
    else                           trig_q <= 1'b0;
  end

  always_comb begin
    req_o      = '0;
    req_o.down = dir_i;
    case (tmr_mode_e'(mode_i))
      MODE_INTCLK: req_o.step = 1'b1;
      MODE_ENC_B: begin
        req_o.hw_dir = 1'b1;
        req_o.step   = rise[PIN_B];
        req_o.down   = lvl_i[PIN_A];
      end
      MODE_ENC_A: begin
        req_o.hw_dir = 1'b1;
        req_o.step   = rise[PIN_A];
        req_o.down   = lvl_i[PIN_B];
      end
      MODE_ENC_X4: begin
        req_o.hw_dir = 1'b1;
        req_o.step   = chg[PIN_A] ^ chg[PIN_B];
        req_o.down   = ~(lvl_i[PIN_A] ^ prev_i[PIN_B]);
      end
      MODE_REINIT: begin
        req_o.step   = 1'b1;
        req_o.reinit = rise[PIN_A];
      end
      MODE_GATED:  req_o.step = lvl_i[PIN_A];
      MODE_TRIG:   req_o.step = trig_q;
      default:     req_o.step = 1'b0;
    endcase
  end

  // R9: once armed in trigger mode the count clock keeps running
  a_r9_trig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_TRIG && trig_q) |=> (mode_i != MODE_TRIG || trig_q));

endmodule

// File: rtl/enc_count_core.sv
module enc_count_core
  import enc_timer_pkg::*;
#(
  parameter int unsigned     CNT_W      = 16,
  parameter logic [CNT_W-1:0] RST_PRESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  step_req_t        req_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             preset_wr_i,
  input  logic [CNT_W-1:0] preset_wdata_i,
  input  logic             preload_en_i,
  input  logic             dir_wr_i,
  input  logic             dir_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] preset_o,
  output logic             dir_o,
  output logic             event_o
);

  logic [CNT_W-1:0] cnt_q, cnt_n, act_q, act_n, sh_q, sh_n;
  logic             pend_q, pend_n, dir_q, dir_n, evt_q, evt_n;

  always_comb begin
    sh_n   = sh_q;
    pend_n = pend_q;
    act_n  = act_q;
    if (preset_wr_i) begin
      sh_n   = preset_wdata_i;
      pend_n = preload_en_i;
      if (!preload_en_i) act_n = preset_wdata_i;
    end

    cnt_n = cnt_q;
    evt_n = 1'b0;
    if (cnt_wr_i) begin
      cnt_n = cnt_wdata_i;
    end else if (en_i) begin
      if (req_i.reinit) begin
        cnt_n = req_i.down ? act_q : '0;
      end else if (req_i.step) begin
        if (!req_i.down) begin
          if (cnt_q == act_q) begin
            cnt_n = '0;
            evt_n = 1'b1;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end else if (cnt_q == '0) begin
          evt_n = 1'b1;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
    end

    // shadow preset moves over on the wrap, before a down reload uses it
    if (evt_n && pend_n) begin
      act_n  = sh_n;
      pend_n = 1'b0;
    end
    if (evt_n && req_i.down) cnt_n = act_n;

    dir_n = dir_q;
    if (req_i.hw_dir) begin
      if (en_i && req_i.step) dir_n = req_i.down;
    end else if (dir_wr_i) begin
      dir_n = dir_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= RST_PRESET;
      sh_q   <= RST_PRESET;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      sh_q   <= sh_n;
      pend_q <= pend_n;
      dir_q  <= dir_n;
      evt_q  <= evt_n;
    end
  end

  assign cnt_o    = cnt_q;
  assign preset_o = act_q;
  assign dir_o    = dir_q;
  assign event_o  = evt_q;

  // R11: a count write always lands
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));

  // R2: disabled and not written means frozen and silent
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !cnt_wr_i) |=> ($stable(cnt_o) && !event_o));

  // R3: an event shows the wrapped value
  a_r3_event_value: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (cnt_o == '0 || cnt_o == preset_o));

  // R10: the active preset only moves on a direct write or an event
  a_r10_preset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_wr_i || preload_en_i) |=> (event_o || $stable(preset_o)));

  // R12: software cannot move the direction in encoder modes
  a_r12_dir_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.hw_dir && !(en_i && req_i.step)) |=> $stable(dir_o));

endmodule

// File: rtl/enc_timer.sv
module enc_timer
  import enc_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [2:0]       mode_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             preset_wr_i,
  input  logic [CNT_W-1:0] preset_wdata_i,
  input  logic             preload_en_i,
  input  logic             dir_wr_i,
  input  logic             dir_wdata_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] preset_o,
  output logic             dir_o,
  output logic             event_o
);

  logic [NUM_PINS-1:0] pins, lvl, prev;
  step_req_t           req;

  assign pins[PIN_A] = pin_a_i;
  assign pins[PIN_B] = pin_b_i;

  enc_pin_sync #(.NPINS(NUM_PINS), .STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .lvl_o(lvl), .prev_o(prev)
  );

  enc_mode_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .lvl_i(lvl), .prev_i(prev),
    .dir_i(dir_o), .req_o(req)
  );

  enc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .req_i(req),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .preset_wr_i(preset_wr_i), .preset_wdata_i(preset_wdata_i),
    .preload_en_i(preload_en_i), .dir_wr_i(dir_wr_i), .dir_wdata_i(dir_wdata_i),
    .cnt_o(cnt_o), .preset_o(preset_o), .dir_o(dir_o), .event_o(event_o)
  );

endmodule

// File: tb/enc_timer_tb.sv
module enc_timer_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en_i = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic         cnt_wr_i = 1'b0;
  logic [W-1:0] cnt_wdata_i = '0;
  logic         preset_wr_i = 1'b0;
  logic [W-1:0] preset_wdata_i = '0;
  logic         preload_en_i = 1'b0;
  logic         dir_wr_i = 1'b0;
  logic         dir_wdata_i = 1'b0;
  logic         pin_a_i = 1'b0;
  logic         pin_b_i = 1'b0;
  logic [W-1:0] cnt_o, preset_o;
  logic         dir_o, event_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  enc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .preset_wr_i(preset_wr_i), .preset_wdata_i(preset_wdata_i),
    .preload_en_i(preload_en_i), .dir_wr_i(dir_wr_i), .dir_wdata_i(dir_wdata_i),
    .pin_a_i(pin_a_i), .pin_b_i(pin_b_i),
    .cnt_o(cnt_o), .preset_o(preset_o), .dir_o(dir_o), .event_o(event_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R12";
    endcase
  endfunction

  // ---------------- reference model, built from the requirements --------
  logic [W-1:0] m_cnt, m_act, m_sh;
  bit m_pend, m_dir, m_evt, m_trig;
  bit [2:0] sa, sb;  // [0] first flop, [1] synced level, [2] previous level
  bit ra, rb, ca, cb, st, dn, ri, hw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_act = '1; m_sh = '1; m_pend = 0; m_dir = 0; m_evt = 0;
      m_trig = 0; sa = 0; sb = 0;
    end else begin
      ra = sa[1] & ~sa[2]; rb = sb[1] & ~sb[2];
      ca = sa[1] ^ sa[2];  cb = sb[1] ^ sb[2];
      st = 0; dn = m_dir; ri = 0; hw = 0;
      case (mode_i)
        3'd0: st = 1;
        3'd1: begin hw = 1; st = rb; dn = sa[1]; end
        3'd2: begin hw = 1; st = ra; dn = sb[1]; end
        3'd3: begin hw = 1; st = ca ^ cb; dn = ~(sa[1] ^ sb[2]); end
        3'd4: begin st = 1; ri = ra; end
        3'd5: st = sa[1];
        3'd6: st = m_trig;
        default: st = 0;
      endcase
      m_trig = (mode_i == 3'd6) ? (m_trig | ra) : 1'b0;
      if (preset_wr_i) begin
        m_sh = preset_wdata_i; m_pend = preload_en_i;
        if (!preload_en_i) m_act_next_direct();
      end
      m_evt = 0;
      if (cnt_wr_i) m_cnt = cnt_wdata_i;
      else if (en_i) begin
        if (ri) m_cnt = dn ? m_act_prev : '0;
        else if (st) begin
          if (!dn) begin
            if (m_cnt == m_act_prev) begin m_cnt = '0; m_evt = 1; end
            else m_cnt = m_cnt + 1'b1;
          end else if (m_cnt == '0) m_evt = 1;
          else m_cnt = m_cnt - 1'b1;
        end
      end
      if (m_evt && m_pend) begin m_act = m_sh; m_pend = 0; end
      if (m_evt && dn) m_cnt = m_act;
      if (hw) begin if (en_i && st) m_dir = dn; end
      else if (dir_wr_i) m_dir = dir_wdata_i;
      sa = {sa[1:0], pin_a_i};
      sb = {sb[1:0], pin_b_i};
    end
    m_act_prev = m_act;
  end

  // active preset as it stood before this edge's update
  logic [W-1:0] m_act_prev = '1;
  task automatic m_act_next_direct();
    m_act = preset_wdata_i;
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(mode_tag(mode_i), {cnt_o, preset_o}, {m_cnt, m_act}, "count/preset vs model");
      chk(mode_tag(mode_i), {30'd0, dir_o, event_o}, {30'd0, m_dir, m_evt}, "dir/event vs model");
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    chk("R1", cnt_o, 0, "count after reset");
    chk("R1", preset_o, 32'hFFFF, "preset after reset");
    chk("R1", {dir_o, event_o}, 0, "dir/event after reset");
    cmp_on = 1'b1;

    // R2: internal clock, then frozen
    mode_i = 3'd0; en_i = 1'b1;
    tick(5);
    chk("R2", cnt_o, 5, "five internal steps");
    en_i = 1'b0;
    tick(3);
    chk("R2", cnt_o, 5, "held while disabled");

    // R11: write while disabled, direct preset write
    cnt_wr_i = 1; cnt_wdata_i = 16'd2; preset_wr_i = 1; preset_wdata_i = 16'd3;
    tick(1);
    cnt_wr_i = 0; preset_wr_i = 0;
    chk("R11", cnt_o, 2, "write while disabled");
    chk("R10", preset_o, 3, "direct preset write");

    // R3: up wrap
    en_i = 1'b1;
    tick(1);
    chk("R3", {cnt_o, 15'd0, event_o}, {16'd3, 16'd0}, "reach preset");
    tick(1);
    chk("R3", {cnt_o, 15'd0, event_o}, {16'd0, 16'd1}, "overflow wrap");
    tick(1);
    chk("R3", {cnt_o, 15'd0, event_o}, {16'd1, 16'd0}, "one-cycle event");
    dir_wr_i = 1; dir_wdata_i = 1;
    tick(1);
    dir_wr_i = 0;
    chk("R2", {cnt_o, 15'd0, dir_o}, {16'd2, 16'd1}, "dir written, old dir used");
    tick(2);
    chk("R3", {cnt_o, 15'd0, event_o}, {16'd0, 16'd0}, "down to zero no event");
    tick(1);
    chk("R3", {cnt_o, 15'd0, event_o}, {16'd3, 16'd1}, "underflow reload");

    // R10: preload defers the preset
    preload_en_i = 1; preset_wr_i = 1; preset_wdata_i = 16'd6;
    tick(1);
    preset_wr_i = 0;
    chk("R10", preset_o, 3, "shadowed preset not active");
    tick(2);
    chk("R10", {cnt_o, preset_o}, {16'd0, 16'd3}, "still old preset");
    tick(1);
    chk("R10", {cnt_o, preset_o}, {16'd6, 16'd6}, "transfer and reload at event");

    // R11: write beats counting
    cnt_wr_i = 1; cnt_wdata_i = 16'd9;
    tick(1);
    cnt_wr_i = 0;
    chk("R11", cnt_o, 9, "write over step");

    // R4: pin_b clocks, pin_a=1 means down
    mode_i = 3'd1; pin_a_i = 1; dir_wr_i = 1; dir_wdata_i = 0;
    tick(4);
    dir_wr_i = 0;
    chk("R12", dir_o, 1, "dir write ignored in encoder mode");
    for (int k = 0; k < 3; k++) begin
      pin_b_i = 1; tick(4); pin_b_i = 0; tick(4);
    end
    chk("R4", {cnt_o, 15'd0, dir_o}, {16'd6, 16'd1}, "three down edges");

    // constrained random against the model
    for (int i = 0; i < 6000; i++) begin
      if (i % 80 == 0) mode_i = 3'($urandom_range(0, 7));
      en_i         = ($urandom_range(0, 15) != 0);
      cnt_wr_i     = ($urandom_range(0, 49) == 0);
      cnt_wdata_i  = 16'($urandom_range(0, 23));
      preset_wr_i  = ($urandom_range(0, 39) == 0);
      preset_wdata_i = 16'($urandom_range(0, 19));
      preload_en_i = 1'($urandom_range(0, 1));
      dir_wr_i     = ($urandom_range(0, 7) == 0);
      dir_wdata_i  = 1'($urandom_range(0, 1));
      if (mode_i == 3'd3) begin
        case ($urandom_range(0, 19))
          0, 1, 2, 3:     if (pin_a_i == pin_b_i) pin_a_i = ~pin_a_i; else pin_b_i = ~pin_b_i;
          4, 5, 6, 7, 8:  if (pin_a_i == pin_b_i) pin_b_i = ~pin_b_i; else pin_a_i = ~pin_a_i;
          9:              begin pin_a_i = ~pin_a_i; pin_b_i = ~pin_b_i; end
          default: ;
        endcase
      end else begin
        if ($urandom_range(0, 4) == 0) pin_a_i = ~pin_a_i;
        if ($urandom_range(0, 4) == 0) pin_b_i = ~pin_b_i;
      end
      tick(1);
    end
    cnt_wr_i = 0; preset_wr_i = 0; dir_wr_i = 0;
    tick(2);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule